// File: doc/BRIEF.md
# Serial Data Register Interface

This block is the data register that sits between a simple register bus and the transmit and receive units of an asynchronous serial controller. Software writes the byte to send through it and reads back the received data, the ninth data bit in each direction and an error summary. Two handshakes happen as side effects of accesses that include the low byte. A write of that byte arms the transmitter through a flag that software cannot see, and a read of that byte sends a one-cycle acknowledge pulse to the receiver.

A mode input selects a frame-based operating mode. While it is high the register is shut off: writes change nothing, reads return zero and no acknowledge is sent. The received parity bit can be forced to zero in the read view, at a bit position chosen by the data length. Four error interrupt requests each pass only when their status flag and their own enable bit are both high.

Two small state machines are at the centre. The transmit commit machine has states TX_IDLE and TX_ARMED. It goes from TX_IDLE to TX_ARMED on a low-byte write. It goes from TX_ARMED to TX_IDLE on the load-accepted pulse, unless a low-byte write happens in the same cycle. A low-byte write while in TX_ARMED keeps it in TX_ARMED. The receive acknowledge machine has states RX_WAIT and RX_ACK. It enters RX_ACK for the cycle after each low-byte read, stays in RX_ACK while low-byte reads come back to back, and otherwise returns to RX_WAIT.

Top module: `sdr_regif`

## Requirements
- R1: After reset, `tx_ready`, `tx_byte`, `tx_ninth` and `rx_taken` are all 0.
- R2: A write transfer (`bus_sel`=1, `bus_wr`=1) with `bus_be[0]`=1 outside frame mode sets `tx_ready` from the next cycle and loads `tx_byte` with `bus_wdata[7:0]`. If `tx_ready` is already 1, the new byte replaces the pending one and `tx_ready` stays 1.
- R3: A `tx_taken` pulse clears `tx_ready` in the next cycle, unless a low-byte write happens in the same cycle, in which case `tx_ready` stays 1.
- R4: A write with `bus_be`=2'b10 loads `tx_ninth` from `bus_wdata[14]` and leaves `tx_ready` and `tx_byte` unchanged.
- R5: During a read transfer outside frame mode, `bus_rdata` holds `rx_ninth` in bit 15, `tx_ninth` in bit 14, `rx_err` in bit 13, 0 in bit 12, and the received word in bits 11:0. `bus_rdata` is 0 whenever no read transfer is in progress.
- R6: Each read transfer with `bus_be[0]`=1 outside frame mode produces `rx_taken`=1 for exactly the next cycle. A read with `bus_be`=2'b10 produces no pulse.
- R7: When `par_en`=1 and `par_mask`=1, read bit 7 is 0 if `len8`=0 and read bit 8 is 0 if `len8`=1. When either `par_en` or `par_mask` is 0, the received word is shown unchanged.
- R8: While `frame_mode`=1, writes leave `tx_ready`, `tx_byte` and `tx_ninth` unchanged, except that `tx_taken` still clears `tx_ready`. Reads return 0 and cause no `rx_taken`.
- R9: `irq[i]` = `st_flags[i]` AND `irq_en[i]`, with bit 0 overrun, bit 1 noise, bit 2 frame error and bit 3 parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Single-cycle bus transfer valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte enables; bit 0 = low byte, bit 1 = upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the transfer cycle |
| frame_mode | input | 1 | Frame-based mode; blocks the register |
| tx_taken | input | 1 | Transmitter accepted the pending byte |
| tx_ready | output | 1 | Commit flag: new transmit data pending |
| tx_byte | output | 8 | Transmit data byte |
| tx_ninth | output | 1 | Transmit ninth bit |
| rx_word | input | 12 | Received data word |
| rx_ninth | input | 1 | Received ninth bit |
| rx_err | input | 1 | Receive error summary |
| rx_taken | output | 1 | Acknowledge pulse to the receiver |
| par_en | input | 1 | Parity enabled |
| len8 | input | 1 | 1 = 8-bit data, 0 = 7-bit data |
| par_mask | input | 1 | Force the received parity bit to 0 |
| st_flags | input | 4 | Error status flags |
| irq_en | input | 4 | Interrupt enables |
| irq | output | 4 | Gated interrupt requests |

## Verification
Three situations are hard to reach from the ports. The first is a `tx_taken` pulse that arrives in the same cycle as a low-byte write while the flag is already set. The second is a string of low-byte reads back to back that has to keep the acknowledge high without merging pulses. The third is a frame-mode write that overlaps a load-accepted pulse. Directed sequences create each of these on purpose. Random traffic is then biased toward active transfers and frequent `tx_taken` pulses, so that all three also come up many times in other orders. A bench model checks every cycle.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_ARMED = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_ACK  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_any;
    } lane_t;

endpackage

// File: rtl/sdr_lane_dec.sv
module sdr_lane_dec
    import sdr_pkg::*;
#(
    parameter int BE_W = 2
) (
    input  logic            sel,
    input  logic            wr,
    input  logic [BE_W-1:0] be,
    input  logic            frame_mode,
    output lane_t           lane
);

    localparam int LO = 0;
    localparam int HI = BE_W - 1;

    logic open_q;

    always_comb begin
        open_q      = sel && !frame_mode;
        lane.wr_lo  = open_q && wr && be[LO];
        lane.wr_hi  = open_q && wr && be[HI];
        lane.rd_lo  = open_q && !wr && be[LO];
        lane.rd_any = open_q && !wr;
    end

endmodule

// File: rtl/sdr_tx_commit.sv
module sdr_tx_commit
    import sdr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_t             lane,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              wninth,
    input  logic              tx_taken,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ninth
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (lane.wr_lo) state_d = TX_ARMED;
            TX_ARMED: if (tx_taken && !lane.wr_lo) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_ready = (state_q == TX_ARMED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_ninth <= 1'b0;
        end else begin
            if (lane.wr_lo) tx_byte  <= wbyte;
            if (lane.wr_hi) tx_ninth <= wninth;
        end
    end

endmodule

// File: rtl/sdr_rx_view.sv
module sdr_rx_view
    import sdr_pkg::*;
#(
    parameter int DW   = 16,
    parameter int RX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lane_t           lane,
    input  logic [RX_W-1:0] rx_word,
    input  logic            rx_ninth,
    input  logic            rx_err,
    input  logic            tx_ninth,
    input  logic            par_en,
    input  logic            len8,
    input  logic            par_mask,
    output logic [DW-1:0]   rdata,
    output logic            rx_taken
);

    localparam int RN_POS  = DW - 1;
    localparam int TN_POS  = DW - 2;
    localparam int ERR_POS = DW - 3;
    localparam int PAR7    = 7;
    localparam int PAR8    = 8;

    rx_state_e state_q, state_d;
    logic [RX_W-1:0] shown;

    always_comb begin
        shown = rx_word;
        if (par_en && par_mask) begin
            if (len8) shown[PAR8] = 1'b0;
            else      shown[PAR7] = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (lane.rd_any) begin
            rdata[RX_W-1:0] = shown;
            rdata[RN_POS]   = rx_ninth;
            rdata[TN_POS]   = tx_ninth;
            rdata[ERR_POS]  = rx_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT: if (lane.rd_lo)  state_d = RX_ACK;
            RX_ACK:  if (!lane.rd_lo) state_d = RX_WAIT;
            default: state_d = RX_WAIT;
        endcase
    end

    always_comb begin
        rx_taken = (state_q == RX_ACK);
    end

endmodule

// File: rtl/sdr_irq_gate.sv
module sdr_irq_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic [N-1:0] req
);

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign req[i] = flags[i] & en[i];
    end

endmodule

// File: rtl/sdr_regif.sv
module sdr_regif
    import sdr_pkg::*;
#(
    parameter int DW     = 16,
    parameter int BYTE_W = 8,
    parameter int RX_W   = 12,
    parameter int N_IRQ  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              frame_mode,
    input  logic              tx_taken,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ninth,
    input  logic [RX_W-1:0]   rx_word,
    input  logic              rx_ninth,
    input  logic              rx_err,
    output logic              rx_taken,
    input  logic              par_en,
    input  logic              len8,
    input  logic              par_mask,
    input  logic [N_IRQ-1:0]  st_flags,
    input  logic [N_IRQ-1:0]  irq_en,
    output logic [N_IRQ-1:0]  irq
);

    localparam int TN_POS = DW - 2;

    lane_t lane;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[DW-1], bus_wdata[TN_POS-1:BYTE_W]};

    sdr_lane_dec #(.BE_W(2)) u_dec (
        .sel        (bus_sel),
        .wr         (bus_wr),
        .be         (bus_be),
        .frame_mode (frame_mode),
        .lane       (lane)
    );

    sdr_tx_commit #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane     (lane),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .wninth   (bus_wdata[TN_POS]),
        .tx_taken (tx_taken),
        .tx_ready (tx_ready),
        .tx_byte  (tx_byte),
        .tx_ninth (tx_ninth)
    );

    sdr_rx_view #(.DW(DW), .RX_W(RX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane     (lane),
        .rx_word  (rx_word),
        .rx_ninth (rx_ninth),
        .rx_err   (rx_err),
        .tx_ninth (tx_ninth),
        .par_en   (par_en),
        .len8     (len8),
        .par_mask (par_mask),
        .rdata    (bus_rdata),
        .rx_taken (rx_taken)
    );

    sdr_irq_gate #(.N(N_IRQ)) u_irq (
        .flags (st_flags),
        .en    (irq_en),
        .req   (irq)
    );

endmodule

// File: rtl/sdr_regif_chk.sv
module sdr_regif_chk #(
    parameter int DW     = 16,
    parameter int BYTE_W = 8,
    parameter int N_IRQ  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_be,
    input logic [DW-1:0]     bus_rdata,
    input logic              frame_mode,
    input logic              tx_taken,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_ninth,
    input logic              rx_taken,
    input logic [N_IRQ-1:0]  st_flags,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [N_IRQ-1:0]  irq
);

    logic lo_wr, hi_only_wr, lo_rd;
    assign lo_wr      = bus_sel && bus_wr && bus_be[0] && !frame_mode;
    assign hi_only_wr = bus_sel && bus_wr && (bus_be == 2'b10);
    assign lo_rd      = bus_sel && !bus_wr && bus_be[0] && !frame_mode;

    AST_ARM_ON_LOW_WR: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> tx_ready); // R2

    AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_taken && !lo_wr) |=> !tx_ready); // R3

    AST_HI_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_only_wr && !tx_ready) |=> (!tx_ready && $stable(tx_byte))); // R4

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> rx_taken); // R6

    AST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> !rx_taken); // R6

    AST_FRAME_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mode |-> (bus_rdata == '0)); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mode |=> ($stable(tx_byte) && $stable(tx_ninth))); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~st_flags) == '0); // R9

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en) == '0); // R9

endmodule

bind sdr_regif sdr_regif_chk #(.DW(DW), .BYTE_W(BYTE_W), .N_IRQ(N_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .frame_mode (frame_mode),
    .tx_taken   (tx_taken),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .tx_ninth   (tx_ninth),
    .rx_taken   (rx_taken),
    .st_flags   (st_flags),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/sim_sdr_regif.sv
module sim_sdr_regif;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        frame_mode = 1'b0, tx_taken = 1'b0;
    logic        tx_ready, tx_ninth, rx_taken;
    logic [7:0]  tx_byte;
    logic [11:0] rx_word = '0;
    logic        rx_ninth = 1'b0, rx_err = 1'b0;
    logic        par_en = 1'b0, len8 = 1'b0, par_mask = 1'b0;
    logic [3:0]  st_flags = '0, irq_en = '0, irq;

    int checks = 0;
    int errors = 0;

    logic       m_ready = 1'b0, m_ninth = 1'b0, m_pulse = 1'b0;
    logic [7:0] m_byte = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_mode(frame_mode), .tx_taken(tx_taken), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_ninth(tx_ninth), .rx_word(rx_word),
        .rx_ninth(rx_ninth), .rx_err(rx_err), .rx_taken(rx_taken),
        .par_en(par_en), .len8(len8), .par_mask(par_mask),
        .st_flags(st_flags), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] shown_word(logic [11:0] w, logic pe, logic l8, logic pm);
        logic [11:0] r = w;
        if (pe && pm) begin
            if (l8) r[8] = 1'b0;
            else    r[7] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (!bus_sel || bus_wr || frame_mode) return 16'h0;
        return {rx_ninth, m_ninth, rx_err, 1'b0,
                shown_word(rx_word, par_en, len8, par_mask)};
    endfunction

    task automatic cyc(logic s, logic w, logic [1:0] b, logic [15:0] d, logic f, logic t);
        logic lo_wr, hi_wr, lo_rd;
        string tag_rd, tag_rdy, tag_byte;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_be = b; bus_wdata = d; frame_mode = f; tx_taken = t;
        #1;
        tag_rd = f ? "R8" : ((par_en && par_mask) ? "R7" : "R5");
        chk(tag_rd, bus_rdata, exp_rdata());
        chk("R9", {12'h0, irq}, {12'h0, st_flags & irq_en});
        lo_wr = s && w && b[0] && !f;
        hi_wr = s && w && b[1] && !f;
        lo_rd = s && !w && b[0] && !f;
        @(posedge clk);
        m_ready = lo_wr ? 1'b1 : (t ? 1'b0 : m_ready);
        if (lo_wr) m_byte = d[7:0];
        if (hi_wr) m_ninth = d[14];
        m_pulse = lo_rd;
        #1;
        tag_rdy  = (s && w && f) ? "R8" : (lo_wr ? "R2" : (hi_wr ? "R4" : "R3"));
        tag_byte = (s && w && f) ? "R8" : ((hi_wr && !lo_wr) ? "R4" : "R2");
        chk(tag_rdy, {15'h0, tx_ready}, {15'h0, m_ready});
        chk(tag_byte, {8'h0, tx_byte}, {8'h0, m_byte});
        chk(tag_byte == "R2" ? "R4" : tag_byte, {15'h0, tx_ninth}, {15'h0, m_ninth});
        chk(f ? "R8" : "R6", {15'h0, rx_taken}, {15'h0, m_pulse});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {15'h0, tx_ready}, 16'h0);
        chk("R1", {8'h0, tx_byte}, 16'h0);
        chk("R1", {15'h0, tx_ninth}, 16'h0);
        chk("R1", {15'h0, rx_taken}, 16'h0);
        chk("R1", bus_rdata, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: arm, then overwrite while armed
        cyc(1, 1, 2'b01, 16'h00A5, 0, 0);
        cyc(1, 1, 2'b01, 16'h003C, 0, 0);
        // R3: accept, then accept together with a new write
        cyc(0, 0, 2'b00, 16'h0, 0, 1);
        cyc(1, 1, 2'b01, 16'h0011, 0, 0);
        cyc(1, 1, 2'b01, 16'h0022, 0, 1);
        cyc(0, 0, 2'b00, 16'h0, 0, 1);
        // R4: upper byte only
        cyc(1, 1, 2'b10, 16'h40FF, 0, 0);
        cyc(1, 1, 2'b11, 16'h0077, 0, 0);
        // R8: frame mode write, read, and accept during frame mode
        cyc(1, 1, 2'b11, 16'h40EE, 1, 0);
        cyc(1, 0, 2'b01, 16'h0, 1, 0);
        cyc(1, 1, 2'b01, 16'h0099, 1, 1);
        // R5/R6/R7: reads under each masking setting
        rx_word = 12'hFFF; rx_ninth = 1; rx_err = 1;
        for (int k = 0; k < 8; k++) begin
            par_en = k[0]; len8 = k[1]; par_mask = k[2];
            cyc(1, 0, 2'b01, 16'h0, 0, 0);
        end
        // R6: back-to-back low reads, then an upper-only read
        cyc(1, 0, 2'b11, 16'h0, 0, 0);
        cyc(1, 0, 2'b01, 16'h0, 0, 0);
        cyc(1, 0, 2'b10, 16'h0, 0, 0);
        cyc(0, 0, 2'b00, 16'h0, 0, 0);
        // R9: each enable alone
        for (int k = 0; k < 4; k++) begin
            st_flags = 4'hF; irq_en = 4'(1 << k);
            cyc(0, 0, 2'b00, 16'h0, 0, 0);
        end

        for (int n = 0; n < N_RAND; n++) begin
            rx_word  = 12'($urandom);
            rx_ninth = 1'($urandom);
            rx_err   = 1'($urandom);
            par_en   = 1'($urandom);
            len8     = 1'($urandom);
            par_mask = 1'($urandom);
            st_flags = 4'($urandom);
            irq_en   = 4'($urandom);
            cyc(($urandom % 4) != 0, 1'($urandom), 2'($urandom), 16'($urandom),
                ($urandom % 7) == 0, ($urandom % 4) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule